// File: doc/BRIEF.md
# Signed-Amount Bidirectional Shifter

This block moves a 16-bit data word left or right under the control of one signed shift amount, so a single unit serves both the left-shift and the right-shift instructions of a small datapath. The amount arrives as a 4-bit field. The block widens it to 16 bits by copying its top bit and reads the result as a two's-complement count. A positive count shifts left. A negative count shifts right by its magnitude. Zero passes the word through unchanged.

The unit has no clock and no state. A decode stage turns the amount into direction strobes and a shift magnitude. A logarithmic shift network then applies that magnitude. Both directions fill vacated positions with zeros, so a right shift is logical and never copies the sign bit. The field can express counts from -8 to +7. A field of binary 1000 therefore shifts right by eight places.

Top module: `bidir_shifter`

## Requirements
- R1: The data input and the result are each 16 bits wide.
- R2: The 4-bit amount field is sign-extended from its bit 3 and read as a two's-complement count. Field values 0000 to 0111 mean +0 to +7, and 1000 to 1111 mean -8 to -1.
- R3: For a count k from +1 to +7, the result equals the data shifted left by k, and bits moved past bit 15 are discarded.
- R4: For a count -n with n from 1 to 8, the result equals the data shifted right by n.
- R5: A count of zero (field 0000) returns the data unchanged.
- R6: Vacated positions are always zero. After a right shift by n, result bits 15 down to 16-n are zero even when data bit 15 is one. After a left shift by k, result bits k-1 down to 0 are zero.
- R7: Field 1000 shifts right by eight positions, giving {8'h00, data[15:8]}.
- R8: The result is a purely combinational function of the present inputs. It follows an input change without any clock edge.
- R9: The result never holds more one bits than the data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | 16 | Word to be shifted |
| shiftAmt | input | 4 | Signed shift count field; negative means right |
| result | output | 16 | Shifted word, zero-filled |

## Verification
The bench sweeps all sixteen amount codes against all-ones, sign-bit-set, alternating and single-bit words, then adds a random run. It compares every cycle against a behavioural model that uses integer arithmetic.

Each corner case targets a specific fault:
- A design that copies the sign bit on right shifts fails on the all-ones and 0x8001 words.
- A design that treats field 1000 as +8, or that masks its magnitude to three bits, gives a wrong or unshifted word at the -8 corner.
- A design whose zero-amount path goes through the reversing path, or that confuses -1 with +1, is caught by the walking-one patterns.
- A design that registers its output misses the mid-cycle check, which changes the inputs between clock edges.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  parameter int SHIFT_DATA_W = 16;
  parameter int SHIFT_AMT_W  = 4;

  typedef struct packed {
    logic                   goLeft;
    logic                   goRight;
    logic [SHIFT_AMT_W-1:0] magnitude;
  } shiftCtrl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int DATA_W = SHIFT_DATA_W,
  parameter int AMT_W  = SHIFT_AMT_W
) (
  input  logic [AMT_W-1:0] shiftAmt,
  output shiftCtrl_t       ctrl
);
  localparam int EXT_W   = DATA_W;
  localparam int MAX_MAG = 2 ** (AMT_W - 1);

  logic [EXT_W-1:0] extAmt;
  logic [AMT_W-1:0] negAmt;

  always_comb begin
    extAmt = {{(EXT_W-AMT_W){shiftAmt[AMT_W-1]}}, shiftAmt};
    negAmt = AMT_W'(0) - shiftAmt;
    ctrl.goRight   = extAmt[EXT_W-1];
    ctrl.goLeft    = !extAmt[EXT_W-1] && (extAmt != '0);
    ctrl.magnitude = extAmt[EXT_W-1] ? negAmt : shiftAmt;
  end

  always_comb begin
    if (!$isunknown(shiftAmt)) begin
      assert_dir_exclusive_R2: assert ($onehot0({ctrl.goLeft, ctrl.goRight}))
        else $error("direction strobes both set");
      assert_mag_range_R7: assert (int'(ctrl.magnitude) <= MAX_MAG)
        else $error("shift magnitude out of range");
      assert_zero_idle_R5: assert ((ctrl.magnitude != '0) || (!ctrl.goLeft && !ctrl.goRight))
        else $error("strobe raised for zero count");
    end
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int DATA_W = SHIFT_DATA_W,
  parameter int AMT_W  = SHIFT_AMT_W
) (
  input  shiftCtrl_t        ctrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int STAGES = AMT_W;

  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stageVal [STAGES+1];

  genvar b, s;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_rev_in
      assign revIn[b] = dataIn[DATA_W-1-b];
    end
  endgenerate

  assign stageVal[0] = ctrl.goRight ? revIn : dataIn;

  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      assign stageVal[s+1] = ctrl.magnitude[s] ? (stageVal[s] << (2 ** s)) : stageVal[s];
    end
    for (b = 0; b < DATA_W; b++) begin : g_rev_out
      assign revOut[b] = stageVal[STAGES][DATA_W-1-b];
    end
  endgenerate

  assign dataOut = ctrl.goRight ? revOut : stageVal[STAGES];

  always_comb begin
    if (!$isunknown({ctrl, dataIn})) begin
      assert_pass_through_R5: assert ((ctrl.magnitude != '0) || (dataOut == dataIn))
        else $error("zero count altered data");
      for (int k = 0; k < DATA_W; k++) begin
        if (ctrl.goLeft && (k < int'(ctrl.magnitude)))
          assert_left_fill_R6: assert (!dataOut[k]) else $error("left fill bit set");
        if (ctrl.goRight && (k >= DATA_W - int'(ctrl.magnitude)))
          assert_right_fill_R6: assert (!dataOut[k]) else $error("right fill bit set");
      end
    end
  end
endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter
  import shifter_pkg::*;
#(
  parameter int DATA_W = SHIFT_DATA_W,
  parameter int AMT_W  = SHIFT_AMT_W
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  output logic [DATA_W-1:0] result
);
  shiftCtrl_t ctrl;

  shift_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_ctrl (
    .shiftAmt (shiftAmt),
    .ctrl     (ctrl)
  );

  shift_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dp (
    .ctrl    (ctrl),
    .dataIn  (dataIn),
    .dataOut (result)
  );

  always_comb begin
    if (!$isunknown({dataIn, shiftAmt})) begin
      assert_no_new_ones_R9: assert ($countones(result) <= $countones(dataIn))
        else $error("shift created one bits");
    end
  end
endmodule

// File: tb/sim_bidir_shifter.sv
module sim_bidir_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dataIn = '0;
  logic [3:0]  shiftAmt = '0;
  logic [15:0] result;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  bidir_shifter u0 (.dataIn(dataIn), .shiftAmt(shiftAmt), .result(result));

  function automatic logic [15:0] model(logic [15:0] d, logic [3:0] f);
    int amt;
    amt = (f >= 8) ? int'(f) - 16 : int'(f);
    if (amt >= 0) return 16'((int'(d) << amt) & 16'hFFFF);
    return 16'(int'(d) >> (-amt));
  endfunction

  function automatic string tagFor(logic [15:0] d, logic [3:0] f);
    if (f == 4'd0) return "R5";
    if (f == 4'b1000) return "R7";
    if (f[3] && d[15]) return "R6";
    if (f[3]) return "R4";
    return "R3";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: data=%h amt=%b actual=%h expected=%h", req, dataIn, shiftAmt, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] d, logic [3:0] f);
    @(posedge clk);
    dataIn = d;
    shiftAmt = f;
    expQ.push_back(model(d, f));
    tagQ.push_back(tagFor(d, f));
    @(negedge clk);
    check(tagQ.pop_front(), result, expQ.pop_front());
    checks++;
    if ($countones(result) > $countones(d)) begin
      fails++;
      $display("FAIL R9: actual ones=%0d expected at most %0d", $countones(result), $countones(d));
    end
  endtask

  initial begin
    logic [15:0] pats [6] = '{16'hFFFF, 16'h8001, 16'hA5C3, 16'h1234, 16'h0001, 16'h8000};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, 16'h0000);
    checks++;
    if ($bits(result) != 16 || $bits(dataIn) != 16) begin
      fails++;
      $display("FAIL R1: actual width=%0d expected=16", $bits(result));
    end
    foreach (pats[p])
      for (int f = 0; f < 16; f++) apply(pats[p], 4'(f));
    apply(16'hFFFF, 4'b1111);
    check("R2", result, 16'h7FFF);
    apply(16'hABCD, 4'b1000);
    check("R7", result, 16'h00AB);
    apply(16'hFFFF, 4'b0111);
    check("R3", result, 16'hFF80);
    for (int i = 0; i < 2000; i++) apply(16'($urandom), 4'($urandom));
    @(posedge clk);
    #1;
    dataIn = 16'h00F0;
    shiftAmt = 4'b1100;
    #0.5;
    check("R8", result, 16'h000F);
    shiftAmt = 4'b0010;
    #0.5;
    check("R8", result, 16'h03C0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule